// File: doc/BRIEF.md
# ATM Cell Receiver for a UTOPIA Level-2 Slave Port

This block is the receive half of a UTOPIA level-2 slave port. A UTOPIA master on the same bus pushes ATM cells into it one bus word per clock. The master picks this port through a 5-bit PHY address. It marks the first word of each cell with start-of-cell and may hold the transfer at any word by dropping its enable. The receiver stores one complete cell in a local buffer. It then presents the whole cell on a valid/ready interface to the logic downstream.

The bus is 16 or 8 bits wide, set by a parameter. In 16-bit mode a cell is 27 words, with one padding byte. In 8-bit mode it is 53 bytes. Each word carries an odd-parity bit. A bad word marks the finished cell with a parity-error flag that stays set for the whole cell. The block tells the master it can take a cell through its cell-available output. That output is driven only while the master addresses this port and the buffer is free.

Top module: `atm_cell_rx`

## Requirements
- R1: A word is captured on a rising clock edge only when `rxEnb` is 1, the port is selected and no finished cell is waiting. The k-th captured word of a cell (k = 0 first) appears at `cellData[k*DATA_W +: DATA_W]`, with bit DATA_W-1 as its msb.
- R2: A cell begins only with a captured word that has `rxSoc` = 1. Words without start-of-cell that arrive while no cell is open are discarded, so a run of them never produces a cell.
- R3: A cycle with `rxEnb` = 0 captures nothing, whatever `rxData` and `rxSoc` carry. The cell then continues at the next enabled word with no loss of alignment. This holds for a pause at any position, including just before the last word.
- R4: `cellValid` rises on the edge that captures the last word of a cell (word 26 for a 16-bit bus, word 52 for an 8-bit bus). It stays high until an edge where `cellReady` is 1, after which it is 0.
- R5: While `cellValid` is 1 and `cellReady` is 0, `cellData` and `cellParErr` do not change.
- R6: Parity is odd: a word is good when `rxData` together with `rxPrty` holds an odd number of ones. `cellParErr` is 1 for a finished cell if any of its words was bad, and a new cell starts with the flag cleared.
- R7: A start-of-cell that arrives before the open cell is complete discards the partial cell, and the new cell starts at word 0.
- R8: During each cycle with `rxEnb` = 0, the port becomes selected if `rxAddr` equals the parameter `PHY_ADDR` and deselected otherwise. The address is ignored while `rxEnb` is 1. Words sent while the port is not selected are not captured.
- R9: `rxClav` is registered. After an edge it is 1 exactly when `rxAddr` equalled `PHY_ADDR` at that edge and `cellValid` is 0 after it. It is therefore never 1 together with `cellValid`.
- R10: After reset, `cellValid`, `cellParErr` and `rxClav` are 0.
- R11: A cell sent while a finished cell is waiting is dropped completely. The waiting cell is left intact, and no cell follows once the waiting one is drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rxData | input | DATA_W | Receive word from the master |
| rxSoc | input | 1 | Start-of-cell marker for the first word |
| rxEnb | input | 1 | Master enable, active high; 0 pauses the transfer |
| rxPrty | input | 1 | Odd-parity bit over `rxData` |
| rxAddr | input | 5 | PHY address from the master |
| rxClav | output | 1 | Cell space available, shown to the addressed master |
| cellData | output | WORDS*DATA_W | Completed cell, word 0 in the low bits |
| cellValid | output | 1 | A completed cell is held on `cellData` |
| cellReady | input | 1 | Downstream accepts the cell |
| cellParErr | output | 1 | Parity error in the held cell |

## Verification
The assertions assume that the master obeys the bus protocol. It changes the selected address only in cycles with enable low, and it does not rely on the port taking words while cell-available is low. Under that assumption a held cell can only leave through the ready handshake, and cell-available can only follow an addressed, free buffer. The stimulus always drives address changes in enable-low cycles. It keeps ready low while checking that a held cell stays stable. Deliberate protocol breaches, such as pushing a cell into a full buffer or sending words without start-of-cell, are checked only at the outputs. They never rely on an assertion.

// File: rtl/atm_cell_rx_pkg.sv
package atm_cell_rx_pkg;
  // index width covers the longest cell (53 words on an 8-bit bus)
  localparam int IDX_W = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic             wrEn;    // capture rxData this edge
    logic             newCell; // first word of a cell: clear parity flag
    logic [IDX_W-1:0] wrIdx;   // target word slot
  } rxStrobe_t;

  function automatic int cellWords(input int dataW);
    return (dataW == 16) ? 27 : 53;
  endfunction
endpackage

// File: rtl/atm_cell_rx_ctrl.sv
module atm_cell_rx_ctrl
  import atm_cell_rx_pkg::*;
#(
  parameter int         WORDS    = 27,
  parameter logic [4:0] PHY_ADDR = 5'd6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxSoc,
  input  logic       rxEnb,
  input  logic [4:0] rxAddr,
  input  logic       cellReady,
  output logic       rxClav,
  output logic       cellValid,
  output rxStrobe_t  strobe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  logic             selected;
  logic             inCell;
  logic [IDX_W-1:0] wordCnt;
  logic             accept, startCell, contCell, lastWord, validNext, addrHit;

  assign addrHit   = (rxAddr == PHY_ADDR);
  assign accept    = rxEnb && selected && !cellValid;
  assign startCell = accept && rxSoc;
  assign contCell  = accept && !rxSoc && inCell;
  assign lastWord  = contCell && (wordCnt == LAST_IDX);
  assign validNext = lastWord || (cellValid && !cellReady);

  always_comb begin
    strobe.wrEn    = startCell || contCell;
    strobe.newCell = startCell;
    strobe.wrIdx   = startCell ? '0 : wordCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selected  <= 1'b0;
      inCell    <= 1'b0;
      wordCnt   <= '0;
      cellValid <= 1'b0;
      rxClav    <= 1'b0;
    end else begin
      if (!rxEnb) selected <= addrHit;
      if (startCell) begin
        inCell  <= 1'b1;
        wordCnt <= IDX_W'(1);
      end else if (contCell) begin
        if (lastWord) begin
          inCell  <= 1'b0;
          wordCnt <= '0;
        end else begin
          wordCnt <= wordCnt + 1'b1;
        end
      end
      cellValid <= validNext;
      rxClav    <= addrHit && !validNext;
    end
  end
endmodule

// File: rtl/atm_cell_rx_dp.sv
module atm_cell_rx_dp
  import atm_cell_rx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORDS  = 27
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DATA_W-1:0]       rxData,
  input  logic                    rxPrty,
  input  rxStrobe_t               strobe,
  output logic [WORDS*DATA_W-1:0] cellData,
  output logic                    cellParErr
);
  logic badWord;
  assign badWord = ~(^{rxData, rxPrty});

  for (genvar g = 0; g < WORDS; g++) begin : g_slot
    logic [DATA_W-1:0] wordReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        wordReg <= '0;
      else if (strobe.wrEn && strobe.wrIdx == IDX_W'(g))
        wordReg <= rxData;
    end
    assign cellData[g*DATA_W +: DATA_W] = wordReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cellParErr <= 1'b0;
    else if (strobe.wrEn)
      cellParErr <= (cellParErr && !strobe.newCell) || badWord;
  end
endmodule

// File: rtl/atm_cell_rx.sv
module atm_cell_rx
  import atm_cell_rx_pkg::*;
#(
  parameter int         DATA_W   = 16,
  parameter logic [4:0] PHY_ADDR = 5'd6,
  localparam int        WORDS    = cellWords(DATA_W)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DATA_W-1:0]       rxData,
  input  logic                    rxSoc,
  input  logic                    rxEnb,
  input  logic                    rxPrty,
  input  logic [4:0]              rxAddr,
  output logic                    rxClav,
  output logic [WORDS*DATA_W-1:0] cellData,
  output logic                    cellValid,
  input  logic                    cellReady,
  output logic                    cellParErr
);
  rxStrobe_t strobe;

  atm_cell_rx_ctrl #(.WORDS(WORDS), .PHY_ADDR(PHY_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxSoc(rxSoc), .rxEnb(rxEnb), .rxAddr(rxAddr),
    .cellReady(cellReady), .rxClav(rxClav), .cellValid(cellValid), .strobe(strobe)
  );

  atm_cell_rx_dp #(.DATA_W(DATA_W), .WORDS(WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxPrty(rxPrty), .strobe(strobe),
    .cellData(cellData), .cellParErr(cellParErr)
  );
endmodule

// File: rtl/atm_cell_rx_chk.sv
module atm_cell_rx_chk #(
  parameter int         DATA_W   = 16,
  parameter int         WORDS    = 27,
  parameter logic [4:0] PHY_ADDR = 5'd6
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [4:0]              rxAddr,
  input logic                    rxClav,
  input logic [WORDS*DATA_W-1:0] cellData,
  input logic                    cellValid,
  input logic                    cellReady,
  input logic                    cellParErr
);
  p_valid_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cellValid && !cellReady) |=> cellValid);

  p_valid_drain_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cellValid && cellReady) |=> !cellValid);

  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cellValid && !cellReady) |=> ($stable(cellData) && $stable(cellParErr)));

  p_clav_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxClav |-> !cellValid);

  p_clav_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxClav |-> ($past(rxAddr) == PHY_ADDR));
endmodule

bind atm_cell_rx atm_cell_rx_chk #(.DATA_W(DATA_W), .WORDS(WORDS), .PHY_ADDR(PHY_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .rxAddr(rxAddr), .rxClav(rxClav), .cellData(cellData),
  .cellValid(cellValid), .cellReady(cellReady), .cellParErr(cellParErr)
);

// File: tb/test_atm_cell_rx.sv
module test_atm_cell_rx;
  localparam int         CLK_PERIOD = 10;
  localparam int         DW         = 16;
  localparam int         NW         = 27;
  localparam logic [4:0] MY_ADDR    = 5'd6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DW-1:0] rxData = '0;
  logic rxSoc = 1'b0, rxEnb = 1'b0, rxPrty = 1'b0, cellReady = 1'b0;
  logic [4:0] rxAddr = 5'd0;
  logic rxClav, cellValid, cellParErr;
  logic [NW*DW-1:0] cellData;

  int nChecks = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atm_cell_rx #(.DATA_W(DW), .PHY_ADDR(MY_ADDR)) i_atm_cell_rx (
    .clk(clk), .rstN(rstN), .rxData(rxData), .rxSoc(rxSoc), .rxEnb(rxEnb),
    .rxPrty(rxPrty), .rxAddr(rxAddr), .rxClav(rxClav), .cellData(cellData),
    .cellValid(cellValid), .cellReady(cellReady), .cellParErr(cellParErr)
  );

  function automatic logic [DW-1:0] wordVal(input int seed, input int k);
    return {8'(seed * 37 + k), 8'(k * 5 + seed)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sample();
    @(posedge clk);
    #1;
  endtask

  // one enable-low cycle; the address presented here selects the port
  task automatic idleCycle(input logic [4:0] addr);
    @(negedge clk);
    rxEnb = 1'b0; rxAddr = addr; rxSoc = 1'b1; rxData = 16'hDEAD; rxPrty = 1'b0;
  endtask

  task automatic sendWord(input logic [DW-1:0] d, input bit soc, input bit bad);
    @(negedge clk);
    rxEnb = 1'b1; rxSoc = soc; rxData = d; rxPrty = bad ? (^d) : ~(^d);
  endtask

  // pauseEvery > 0 also pauses just before the last word
  task automatic sendCell(input int seed, input int nWords, input int pauseEvery,
                          input int badIdx, input bit withSoc);
    for (int k = 0; k < nWords; k++) begin
      if (pauseEvery > 0 && k > 0 && (k % pauseEvery == 0 || k == NW - 1)) begin
        idleCycle(rxAddr);
        if (k == NW - 1) begin
          sample();
          check(cellValid == 1'b0, "R3", "valid during pause before last word",
                64'(cellValid), 64'd0);
        end
      end
      sendWord(wordVal(seed, k), withSoc && k == 0, k == badIdx);
    end
    sample();
  endtask

  task automatic checkCell(input int seed, input bit expErr, input string req);
    int bad = -1;
    for (int k = 0; k < NW; k++)
      if (bad < 0 && cellData[k*DW +: DW] !== wordVal(seed, k)) bad = k;
    check(cellValid === 1'b1, req, "cellValid", 64'(cellValid), 64'd1);
    if (bad >= 0)
      check(1'b0, req, $sformatf("cell word %0d", bad),
            64'(cellData[bad*DW +: DW]), 64'(wordVal(seed, bad)));
    else
      check(1'b1, req, "cell data", 64'd0, 64'd0);
    check(cellParErr === expErr, "R6", "parity flag", 64'(cellParErr), 64'(expErr));
  endtask

  task automatic drain();
    @(negedge clk); rxEnb = 1'b0; cellReady = 1'b1;
    sample();
    check(cellValid == 1'b0, "R4", "valid after ready", 64'(cellValid), 64'd0);
    @(negedge clk); cellReady = 1'b0;
  endtask

  task automatic testReset();
    check(cellValid == 1'b0 && cellParErr == 1'b0 && rxClav == 1'b0, "R10",
          "reset outputs", 64'({cellValid, cellParErr, rxClav}), 64'd0);
  endtask

  task automatic testBasic();
    idleCycle(MY_ADDR);
    sample();
    check(rxClav == 1'b1, "R9", "clav when addressed and free", 64'(rxClav), 64'd1);
    sendCell(1, NW, 0, -1, 1'b1);
    checkCell(1, 1'b0, "R1");
    check(rxClav == 1'b0, "R9", "clav with cell held", 64'(rxClav), 64'd0);
    idleCycle(MY_ADDR);
    sample(); sample(); sample();
    checkCell(1, 1'b0, "R5");
    drain();
    sample();
    check(rxClav == 1'b1, "R9", "clav after drain", 64'(rxClav), 64'd1);
  endtask

  task automatic testPause();
    sendCell(2, NW, 4, -1, 1'b1);
    checkCell(2, 1'b0, "R3");
    drain();
  endtask

  task automatic testParity();
    sendCell(3, NW, 0, 13, 1'b1);
    checkCell(3, 1'b1, "R6");
    drain();
    sendCell(4, NW, 0, -1, 1'b1);
    checkCell(4, 1'b0, "R6");
    drain();
  endtask

  task automatic testEarlySoc();
    sendCell(5, 10, 0, 2, 1'b1);
    check(cellValid == 1'b0, "R7", "partial cell not valid", 64'(cellValid), 64'd0);
    sendCell(6, NW, 0, -1, 1'b1);
    checkCell(6, 1'b0, "R7");
    drain();
  endtask

  task automatic testAddress();
    idleCycle(5'd9);
    sample();
    check(rxClav == 1'b0, "R9", "clav for other address", 64'(rxClav), 64'd0);
    sendCell(7, NW, 0, -1, 1'b1);
    idleCycle(5'd9);
    sample(); sample();
    check(cellValid == 1'b0, "R8", "cell for other port ignored", 64'(cellValid), 64'd0);
    idleCycle(MY_ADDR);
    sendCell(8, NW, 0, -1, 1'b1);
    checkCell(8, 1'b0, "R8");
    drain();
  endtask

  task automatic testNoSoc();
    sendCell(10, NW, 0, -1, 1'b0);
    idleCycle(MY_ADDR);
    sample(); sample();
    check(cellValid == 1'b0, "R2", "words without start-of-cell", 64'(cellValid), 64'd0);
    sendCell(11, 3, 0, -1, 1'b0);
    sendCell(12, NW, 0, -1, 1'b1);
    checkCell(12, 1'b0, "R2");
    drain();
  endtask

  task automatic testFull();
    sendCell(13, NW, 0, -1, 1'b1);
    sendCell(14, NW, 0, 3, 1'b1);
    checkCell(13, 1'b0, "R11");
    drain();
    idleCycle(MY_ADDR);
    sample(); sample(); sample();
    check(cellValid == 1'b0, "R11", "dropped cell never appears", 64'(cellValid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk); rstN = 1'b1;
    testBasic();
    testPause();
    testParity();
    testEarlySoc();
    testAddress();
    testNoSoc();
    testFull();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule